// File: doc/BRIEF.md
# Protected Option Register with Deferred Load

This block holds one 32-bit option word that a bus master programs. Each write carries a privilege flag and byte enables. The write then passes through layered gating before it reaches a pending copy of the word. There are three layers. Privilege decides whether the write counts at all. A debug-area lock guards the SRAM partition fields. A boot lock guards the boot-select bit and the 16-bit boot offset. A read returns the pending copy at any time, whatever the privilege.

The values that drive the block's outputs live in a separate active copy. The active copy loads from the pending copy only on an option-load pulse. The block uses the active copy in two ways:
- It forms the reset address of a second processor, as an offset from either the SRAM base or the flash base.
- It answers a per-access question: is a given offset inside SRAM region 1 or SRAM region 2 secure? The answer depends on a global security-off input, a disable bit for each region, and a start page for each region in 1 KB units.

Top module: `optreg_guard`

## Requirements
- R1: A write with `wr_priv`=0 changes no bit of the word and makes `illegal_wr` high for exactly the one cycle that follows the write edge. Privileged writes never raise `illegal_wr`. Reads are open to any caller.
- R2: When `dbg_area`=0 and `dbg_lock_dis`=1, writes to bits 30:25 and 23:18 are ignored. When `dbg_area`=1 or `dbg_lock_dis`=0, those bits take the written data.
- R3: While `boot_lock`=1, writes to bit 31 (boot select) and bits 15:0 (boot offset) are ignored, and `rd_data` still shows their stored values.
- R4: Accepted writes change only the pending copy, which `rd_data` shows on the cycle after the write edge. The active copy, and with it `boot_addr` and `chk_secure`, changes only on the edge after `opt_load`=1 is sampled, and then takes the pending value.
- R5: `boot_addr` is 0x2000_0000 plus the active offset (bits 15:0) when active bit 31 is 0. It is 0x0800_0000 plus that offset when bit 31 is 1.
- R6: Bits 24, 17 and 16 are reserved. They cannot be written and always read as the matching bits of the `RST_WORD` parameter.
- R7: The region 1 start page is bits 29:25 and the region 2 start page is bits 22:18. A page value p starts at offset p×0x400, so page 0 starts at 0x0000 and page 0x1F at 0x7C00.
- R8: With `sec_off`=1, `chk_secure` is 0 for both regions. With `sec_off`=0, a region whose disable bit is 1 also reports 0. Bit 30 is the disable bit for region 1 and bit 23 for region 2.
- R9: With `sec_off`=0 and the region's disable bit 0, `chk_secure` is 1 exactly when `chk_ofs` is at or above the region's start offset. `chk_region`=0 selects region 1 and `chk_region`=1 selects region 2.
- R10: Byte enables restrict a write. `wr_be[i]` covers bits 8i+7:8i, and inside an enabled byte only the bits that every lock allows are changed.
- R11: After reset, the pending and active copies both equal `RST_WORD` and `illegal_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_priv | input | 1 | Write is privileged |
| wr_be | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Pending option word |
| dbg_area | input | 1 | Debug-area flag; 1 opens the partition fields |
| dbg_lock_dis | input | 1 | Debug lock; with `dbg_area`=0 it blocks the partition fields |
| boot_lock | input | 1 | Blocks boot select and boot offset writes |
| opt_load | input | 1 | Copies pending into active |
| sec_off | input | 1 | Global security disable |
| chk_region | input | 1 | Region under test: 0 region 1, 1 region 2 |
| chk_ofs | input | 15 | Byte offset inside the region |
| illegal_wr | output | 1 | One-cycle unprivileged-write event |
| boot_addr | output | 32 | Boot reset address of the second processor |
| chk_secure | output | 1 | Queried offset is secure |

## Verification
A wrong write mask shows up on `rd_data` one cycle after the write edge, so every gating layer can be checked the moment a write lands. A fault in the active copy or in the load path stays hidden until `opt_load`. It then shows on `boot_addr` at the next edge, and through `chk_secure` only when the queried offset sits next to a start page. For that reason the bench queries offsets on both sides of each boundary it programs.

// File: rtl/optreg_pkg.sv
package optreg_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTES      = WORD_W / 8;
  localparam int PAGE_W     = 5;
  localparam int PAGE_SHIFT = 10;
  localparam int REG_OFS_W  = PAGE_W + PAGE_SHIFT;
  localparam int BOOT_OFS_W = 16;

  localparam int BOOT_SEL_BIT = 31;
  localparam int R1_DIS_BIT   = 30;
  localparam int R1_PG_LSB    = 25;
  localparam int R2_DIS_BIT   = 23;
  localparam int R2_PG_LSB    = 18;

  localparam logic [WORD_W-1:0] BOOT_FIELDS = 32'h8000_FFFF;
  localparam logic [WORD_W-1:0] PART_FIELDS = 32'h7EFC_0000;
  localparam logic [WORD_W-1:0] RSVD_FIELDS = ~(BOOT_FIELDS | PART_FIELDS);

  localparam logic [WORD_W-1:0] SRAM_BASE  = 32'h2000_0000;
  localparam logic [WORD_W-1:0] FLASH_BASE = 32'h0800_0000;

  function automatic logic [WORD_W-1:0] boot_target(input logic sel,
                                                    input logic [BOOT_OFS_W-1:0] ofs);
    logic [WORD_W-1:0] base;
    base = sel ? FLASH_BASE : SRAM_BASE;
    return base + {{(WORD_W-BOOT_OFS_W){1'b0}}, ofs};
  endfunction

  function automatic logic [REG_OFS_W-1:0] page_start(input logic [PAGE_W-1:0] pg);
    return {pg, {PAGE_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/optreg_wmask.sv
module optreg_wmask
  import optreg_pkg::*;
(
  input  logic              wr_priv,
  input  logic [BYTES-1:0]  wr_be,
  input  logic              dbg_area,
  input  logic              dbg_lock_dis,
  input  logic              boot_lock,
  output logic [WORD_W-1:0] wmask
);
  logic [WORD_W-1:0] be_mask;
  logic [WORD_W-1:0] field_mask;
  logic              part_open;

  for (genvar i = 0; i < BYTES; i++) begin : g_be
    assign be_mask[8*i +: 8] = {8{wr_be[i]}};
  end

  assign part_open = dbg_area | ~dbg_lock_dis;

  always_comb begin
    field_mask = '0;
    if (!boot_lock) field_mask = field_mask | BOOT_FIELDS;
    if (part_open)  field_mask = field_mask | PART_FIELDS;
  end

  assign wmask = wr_priv ? (be_mask & field_mask) : '0;
endmodule

// File: rtl/optreg_store.sv
module optreg_store
  import optreg_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [WORD_W-1:0] wmask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              opt_load,
  output logic [WORD_W-1:0] pend,
  output logic [WORD_W-1:0] act
);
  logic [WORD_W-1:0] pend_nxt;

  assign pend_nxt = wr_go ? ((pend & ~wmask) | (wr_data & wmask)) : pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= RST_WORD;
      act  <= RST_WORD;
    end else begin
      pend <= pend_nxt;
      if (opt_load) act <= pend;
    end
  end
endmodule

// File: rtl/optreg_attr.sv
module optreg_attr
  import optreg_pkg::*;
(
  input  logic                 sec_off,
  input  logic [WORD_W-1:0]    act,
  input  logic                 chk_region,
  input  logic [REG_OFS_W-1:0] chk_ofs,
  output logic                 chk_secure
);
  logic [PAGE_W-1:0] pg_r1, pg_r2, pg_sel;
  logic              dis_sel;

  assign pg_r1   = act[R1_PG_LSB +: PAGE_W];
  assign pg_r2   = act[R2_PG_LSB +: PAGE_W];
  assign pg_sel  = chk_region ? pg_r2 : pg_r1;
  assign dis_sel = chk_region ? act[R2_DIS_BIT] : act[R1_DIS_BIT];

  assign chk_secure = ~sec_off & ~dis_sel & (chk_ofs >= page_start(pg_sel));
endmodule

// File: rtl/optreg_guard.sv
module optreg_guard
  import optreg_pkg::*;
#(
  parameter logic [31:0] RST_WORD = 32'h0000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_priv,
  input  logic [3:0]           wr_be,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic                 dbg_area,
  input  logic                 dbg_lock_dis,
  input  logic                 boot_lock,
  input  logic                 opt_load,
  input  logic                 sec_off,
  input  logic                 chk_region,
  input  logic [14:0]          chk_ofs,
  output logic                 illegal_wr,
  output logic [31:0]          boot_addr,
  output logic                 chk_secure
);
  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] pend_word;
  logic [WORD_W-1:0] act_word;
  logic              priv_fault;

  assign priv_fault = wr_en & ~wr_priv;

  optreg_wmask u_wmask (
    .wr_priv      (wr_priv),
    .wr_be        (wr_be),
    .dbg_area     (dbg_area),
    .dbg_lock_dis (dbg_lock_dis),
    .boot_lock    (boot_lock),
    .wmask        (wmask)
  );

  optreg_store #(.RST_WORD(RST_WORD)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (wr_en),
    .wmask    (wmask),
    .wr_data  (wr_data),
    .opt_load (opt_load),
    .pend     (pend_word),
    .act      (act_word)
  );

  optreg_attr u_attr (
    .sec_off    (sec_off),
    .act        (act_word),
    .chk_region (chk_region),
    .chk_ofs    (chk_ofs),
    .chk_secure (chk_secure)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_wr <= 1'b0;
    else        illegal_wr <= priv_fault;
  end

  assign rd_data   = pend_word;
  assign boot_addr = boot_target(act_word[BOOT_SEL_BIT], act_word[BOOT_OFS_W-1:0]);
endmodule

// File: rtl/optreg_guard_chk.sv
module optreg_guard_chk #(
  parameter logic [31:0] RST_WORD = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_priv,
  input logic        dbg_area,
  input logic        dbg_lock_dis,
  input logic        boot_lock,
  input logic        opt_load,
  input logic        sec_off,
  input logic [31:0] rd_data,
  input logic [31:0] boot_addr,
  input logic        illegal_wr,
  input logic        chk_secure,
  input logic        priv_fault
);
  localparam logic [31:0] RSVD = 32'h0103_0000;

  p_illegal_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv) |=> illegal_wr);
  p_illegal_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_fault |=> !illegal_wr);
  p_unpriv_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv) |=> $stable(rd_data));
  p_part_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dbg_area && dbg_lock_dis) |=> $stable(rd_data[30:18]));
  p_boot_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && boot_lock) |=> ($stable(rd_data[31]) && $stable(rd_data[15:0])));
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_load |=> $stable(boot_addr));
  p_load_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    opt_load |=> (boot_addr[15:0] == $past(rd_data[15:0])));
  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & RSVD) == (RST_WORD & RSVD)));
  p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_off |-> !chk_secure);
endmodule

bind optreg_guard optreg_guard_chk #(.RST_WORD(RST_WORD)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_priv      (wr_priv),
  .dbg_area     (dbg_area),
  .dbg_lock_dis (dbg_lock_dis),
  .boot_lock    (boot_lock),
  .opt_load     (opt_load),
  .sec_off      (sec_off),
  .rd_data      (rd_data),
  .boot_addr    (boot_addr),
  .illegal_wr   (illegal_wr),
  .chk_secure   (chk_secure),
  .priv_fault   (priv_fault)
);

// File: tb/optreg_guard_tb.sv
module optreg_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_priv = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        dbg_area = 1'b0, dbg_lock_dis = 1'b0, boot_lock = 1'b0;
  logic        opt_load = 1'b0, sec_off = 1'b0, chk_region = 1'b0;
  logic [14:0] chk_ofs = '0;
  logic [31:0] rd_data, boot_addr;
  logic        illegal_wr, chk_secure;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  optreg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .dbg_area(dbg_area),
    .dbg_lock_dis(dbg_lock_dis), .boot_lock(boot_lock), .opt_load(opt_load),
    .sec_off(sec_off), .chk_region(chk_region), .chk_ofs(chk_ofs),
    .illegal_wr(illegal_wr), .boot_addr(boot_addr), .chk_secure(chk_secure)
  );

  // fields: priv, be, data, dbg_area, dbg_lock_dis, boot_lock, expected rd, expected event
  localparam int NV = 8;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'hFEFC_FFFF, 1'b0}, // R6 R2 R3 open
    {1'b0, 4'hF, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'hFEFC_FFFF, 1'b1}, // R1
    {1'b1, 4'hF, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h7EFC_0000, 1'b0}, // R2 locked
    {1'b1, 4'hF, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0}, // R3 locked, R2 area open
    {1'b1, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 32'h7EFC_0000, 1'b0}, // R3
    {1'b1, 4'h3, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 32'h7EFC_5678, 1'b0}, // R10
    {1'b1, 4'h8, 32'hA500_0000, 1'b0, 1'b0, 1'b0, 32'hA4FC_5678, 1'b0}, // R10 R6
    {1'b0, 4'hF, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'hA4FC_5678, 1'b1}  // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic p, input logic [3:0] be, input logic [31:0] d,
                          input logic a, input logic l, input logic bl);
    @(negedge clk);
    wr_en = 1'b1; wr_priv = p; wr_be = be; wr_data = d;
    dbg_area = a; dbg_lock_dis = l; boot_lock = bl;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk);
    opt_load = 1'b1;
    @(negedge clk);
    opt_load = 1'b0;
  endtask

  task automatic query(input logic rg, input logic [14:0] o, input logic so,
                       input logic exp, input string req);
    chk_region = rg; chk_ofs = o; sec_off = so;
    #1;
    check(req, {31'b0, chk_secure}, {31'b0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rd", rd_data, 32'h0);
    check("R11 event", {31'b0, illegal_wr}, 32'h0);
    check("R11 boot", boot_addr, 32'h2000_0000);
    query(1'b0, 15'h0, 1'b0, 1'b1, "R11 secure default");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][72], VEC[i][71:68], VEC[i][67:36], VEC[i][35], VEC[i][34], VEC[i][33]);
      check($sformatf("R1/R2/R3/R10 vec%0d rd", i), rd_data, VEC[i][32:1]);
      check($sformatf("R1 vec%0d event", i), {31'b0, illegal_wr}, {31'b0, VEC[i][0]});
    end
    @(negedge clk);
    check("R1 event one cycle", {31'b0, illegal_wr}, 32'h0);

    // R4: nothing active yet
    check("R4 before load", boot_addr, 32'h2000_0000);
    do_load();
    check("R5 flash boot", boot_addr, 32'h0800_5678);
    // region 1 page 18 -> 0x4800 (R7, R9)
    query(1'b0, 15'h4800, 1'b0, 1'b1, "R9 at start");
    query(1'b0, 15'h47FF, 1'b0, 1'b0, "R9 below start");
    query(1'b0, 15'h7FFF, 1'b1, 1'b0, "R8 global off");
    query(1'b1, 15'h7FFF, 1'b0, 1'b0, "R8 region2 disabled");

    // R4: pending write does not move active
    do_write(1'b1, 4'h3, 32'h0000_0010, 1'b0, 1'b0, 1'b0);
    check("R4 pending", rd_data, 32'hA4FC_0010);
    check("R4 active held", boot_addr, 32'h0800_5678);
    // clear boot select and region2 fields
    do_write(1'b1, 4'hC, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
    check("R6 pending", rd_data, 32'h0000_0010);
    do_load();
    check("R5 sram boot", boot_addr, 32'h2000_0010);
    query(1'b1, 15'h0000, 1'b0, 1'b1, "R7 page0 region2");
    query(1'b0, 15'h0000, 1'b0, 1'b1, "R7 page0 region1");
    // region2 top page 0x1F -> 0x7C00
    do_write(1'b1, 4'h4, 32'h007C_0000, 1'b1, 1'b0, 1'b0);
    do_load();
    query(1'b1, 15'h7C00, 1'b0, 1'b1, "R7 top page at");
    query(1'b1, 15'h7BFF, 1'b0, 1'b0, "R7 top page below");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule